// File: doc/BRIEF.md
# Two-Pair Banked Word Memory

This block stores eight 4-bit words in four small storage banks, each bank holding four 2-bit entries. Every system word is split in two: its low half (bits 1:0) lives in one bank of a pair and its high half (bits 3:2) in the other bank of the same pair. An address mapper picks which pair serves an access and which entry inside the two banks is used. Each bank has its own select, write and output controls, and a bank drives nothing unless it is selected for a read.

A build-time parameter sets how addresses are spread over the two pairs. With top-bit spreading, address bit 2 picks the pair, so the lower four addresses share one pair and the upper four share the other. With bottom-bit spreading, address bit 0 picks the pair, so neighbouring addresses fall in different pairs. A second parameter chooses a read path that settles in the same cycle or one that is captured in a register and appears one clock later. Writes always take effect on the rising clock edge.

Top module: `banked_word_mem`

## Requirements
- R1: After a write of data D to address A, a later read of A returns D on `rdata` with `rvalid` high, in either spreading mode.
- R2: With top-bit spreading and `acc_en` high, `bank_act` is 4'b0011 when address bit 2 is 0 and 4'b1100 when it is 1 (bank 2p holds the low half and bank 2p+1 the high half of pair p).
- R3: With bottom-bit spreading and `acc_en` high, `bank_act` is 4'b0011 when address bit 0 is 0 and 4'b1100 when it is 1.
- R4: Every access enables exactly two banks, one per data half, and `bank_act` is 4'b0000 while `acc_en` is low.
- R5: While `acc_en` is low a write request stores nothing: the addressed word keeps its earlier value.
- R6: With `acc_en` high but both `wr_en` and `rd_en` low, no word changes and no bank drives read data.
- R7: Whenever no bank drives read data, `rdata` is 4'h0 and `rvalid` is 0.
- R8: With the registered read path, `rdata` and `rvalid` for a read request show after the next rising edge; with the direct path they show in the request cycle.
- R9: Reset clears the registered read output to `rdata`=0, `rvalid`=0 and leaves stored words unchanged.
- R10: A read and a write to the same address in one cycle returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and the registered read use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_en | input | 1 | Access enable; selects the bank pair for the address |
| wr_en | input | 1 | Write request for the selected pair |
| rd_en | input | 1 | Read request; lets the selected pair drive data |
| addr | input | 3 | System word address |
| wdata | input | 4 | Write data; bits 1:0 go to the low-half bank, bits 3:2 to the high-half bank |
| rdata | output | 4 | Read data, zero when no bank drives |
| rvalid | output | 1 | High when read data comes from a selected bank |
| bank_act | output | 4 | Per-bank select lines, bank index = bit position |

## Verification
The hardest case to reach from the ports is a read that coincides with a write to the same word, because the answer depends on whether the stored value changes before or after the read path captures it. The stimulus raises write and read together on a word that already holds a known value, checks the direct path before the edge and the registered path just after it, then reads the word again to see the new value. Both spreading modes are driven from one stimulus stream by two instances, so the same addresses show different `bank_act` patterns while returning identical data.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  typedef enum logic {
    SPREAD_LOW  = 1'b0,
    SPREAD_HIGH = 1'b1
  } spread_mode_e;

endpackage

// File: rtl/bwm_bank.sv
module bwm_bank #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             cs,
  input  logic             we,
  input  logic             oe,
  input  logic [AW-1:0]    row,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             drv
);

  logic [DEPTH-1:0]            row_sel;
  logic [DEPTH-1:0][WIDTH-1:0] row_q;

  // row decoder, one-hot
  always_comb begin
    row_sel      = '0;
    row_sel[row] = 1'b1;
  end

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic             wr_row;
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] q_nxt;

    assign wr_row = cs && we && row_sel[r];

    always_comb begin
      q_nxt = q;
      if (wr_row) q_nxt = din;
    end

    always_ff @(posedge clk) begin
      q <= q_nxt;
    end

    assign row_q[r] = q;
  end

  assign drv  = cs && oe;
  assign dout = drv ? row_q[row] : '0;

endmodule

// File: rtl/bwm_addr_map.sv
module bwm_addr_map #(
  parameter bwm_pkg::spread_mode_e MODE = bwm_pkg::SPREAD_HIGH,
  parameter int ADDR_W = 3,
  parameter int BAW    = 2,
  localparam int PSEL_W = ADDR_W - BAW,
  localparam int NPAIR  = 2 ** PSEL_W,
  localparam int NBANK  = 2 * NPAIR
) (
  input  logic              acc_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NBANK-1:0]  bank_cs,
  output logic [BAW-1:0]    loc_addr
);

  logic [PSEL_W-1:0] pair;

  if (MODE == bwm_pkg::SPREAD_HIGH) begin : g_high
    assign pair     = addr[ADDR_W-1 -: PSEL_W];
    assign loc_addr = addr[BAW-1:0];
  end else begin : g_low
    assign pair     = addr[PSEL_W-1:0];
    assign loc_addr = addr[ADDR_W-1:PSEL_W];
  end

  always_comb begin
    bank_cs = '0;
    for (int p = 0; p < NPAIR; p++) begin
      bank_cs[2*p]   = acc_en && (pair == PSEL_W'(p));
      bank_cs[2*p+1] = acc_en && (pair == PSEL_W'(p));
    end
  end

endmodule

// File: rtl/bwm_read_merge.sv
module bwm_read_merge #(
  parameter int NBANK    = 4,
  parameter int HALF_W   = 2,
  parameter bit REG_READ = 1'b1,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NBANK-1:0][HALF_W-1:0] bank_dout,
  input  logic [NBANK-1:0]             bank_drv,
  output logic [DATA_W-1:0]            rdata,
  output logic                         rvalid
);

  logic [HALF_W-1:0] mrg_lo;
  logic [HALF_W-1:0] mrg_hi;
  logic              mrg_vld;

  always_comb begin
    mrg_lo  = '0;
    mrg_hi  = '0;
    mrg_vld = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      if (b % 2 == 0) mrg_lo = mrg_lo | bank_dout[b];
      else            mrg_hi = mrg_hi | bank_dout[b];
      mrg_vld = mrg_vld | bank_drv[b];
    end
  end

  if (REG_READ) begin : g_reg
    logic [DATA_W-1:0] rd_q, rd_nxt;
    logic              vl_q, vl_nxt;

    always_comb begin
      rd_nxt = {mrg_hi, mrg_lo};
      vl_nxt = mrg_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q <= '0;
        vl_q <= 1'b0;
      end else begin
        rd_q <= rd_nxt;
        vl_q <= vl_nxt;
      end
    end

    assign rdata  = rd_q;
    assign rvalid = vl_q;
  end else begin : g_comb
    assign rdata  = {mrg_hi, mrg_lo};
    assign rvalid = mrg_vld;
  end

endmodule

// File: rtl/banked_word_mem.sv
module banked_word_mem #(
  parameter bwm_pkg::spread_mode_e MODE = bwm_pkg::SPREAD_HIGH,
  parameter bit REG_READ   = 1'b1,
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 4,
  parameter int BANK_DEPTH = 4,
  localparam int HALF_W = DATA_W / 2,
  localparam int BAW    = $clog2(BANK_DEPTH),
  localparam int NPAIR  = 2 ** (ADDR_W - BAW),
  localparam int NBANK  = 2 * NPAIR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [NBANK-1:0]  bank_act
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  logic [NBANK-1:0]             bank_cs;
  logic [BAW-1:0]               loc_addr;
  logic [NBANK-1:0][HALF_W-1:0] bank_dout;
  logic [NBANK-1:0]             bank_drv;

  bwm_addr_map #(
    .MODE   (MODE),
    .ADDR_W (ADDR_W),
    .BAW    (BAW)
  ) u_map (
    .acc_en   (acc_en),
    .addr     (addr),
    .bank_cs  (bank_cs),
    .loc_addr (loc_addr)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bwm_bank #(
      .DEPTH (BANK_DEPTH),
      .WIDTH (HALF_W)
    ) u_bank (
      .clk  (clk),
      .cs   (bank_cs[b]),
      .we   (wr_en),
      .oe   (rd_en),
      .row  (loc_addr),
      .din  (wdata[(b % 2)*HALF_W +: HALF_W]),
      .dout (bank_dout[b]),
      .drv  (bank_drv[b])
    );
  end

  bwm_read_merge #(
    .NBANK    (NBANK),
    .HALF_W   (HALF_W),
    .REG_READ (REG_READ)
  ) u_merge (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .bank_dout (bank_dout),
    .bank_drv  (bank_drv),
    .rdata     (rdata),
    .rvalid    (rvalid)
  );

  assign bank_act = bank_cs;

  // ---------------- assertions ----------------
  a_r4_two_banks: assert property (@(posedge clk) disable iff (!rst_n_i)
    $countones(bank_act) == (acc_en ? 2 : 0));

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    !rvalid |-> (rdata == '0));

  if (MODE == bwm_pkg::SPREAD_HIGH) begin : g_a_high
    a_r2_top_bit: assert property (@(posedge clk) disable iff (!rst_n_i)
      acc_en |-> (addr[ADDR_W-1] ? (bank_act[NBANK-1 -: 2] == 2'b11)
                                 : (bank_act[1:0] == 2'b11)));
  end else begin : g_a_low
    a_r3_bottom_bit: assert property (@(posedge clk) disable iff (!rst_n_i)
      acc_en |-> (addr[0] ? (bank_act[NBANK-1 -: 2] == 2'b11)
                          : (bank_act[1:0] == 2'b11)));
  end

  if (REG_READ) begin : g_a_reg
    a_r8_reg_latency: assert property (@(posedge clk) disable iff (!rst_n_i)
      (acc_en && rd_en) |=> rvalid);
    a_r6_no_drive_reg: assert property (@(posedge clk) disable iff (!rst_n_i)
      !(acc_en && rd_en) |=> !rvalid);
  end else begin : g_a_comb
    a_r8_comb_latency: assert property (@(posedge clk) disable iff (!rst_n_i)
      (acc_en && rd_en) |-> rvalid);
    a_r6_no_drive_comb: assert property (@(posedge clk) disable iff (!rst_n_i)
      !(acc_en && rd_en) |-> !rvalid);
  end

endmodule

// File: tb/banked_word_mem_test.sv
`timescale 1ns/1ps
module banked_word_mem_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_en, wr_en, rd_en;
  logic [2:0] addr;
  logic [3:0] wdata;

  logic [3:0] rdata_h, rdata_l;
  logic       rvalid_h, rvalid_l;
  logic [3:0] act_h, act_l;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  // top-bit spreading, registered read
  banked_word_mem #(.MODE(bwm_pkg::SPREAD_HIGH), .REG_READ(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_h), .rvalid(rvalid_h), .bank_act(act_h)
  );

  // bottom-bit spreading, direct read
  banked_word_mem #(.MODE(bwm_pkg::SPREAD_LOW), .REG_READ(1'b0)) uut_lo (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_l), .rvalid(rvalid_l), .bank_act(act_l)
  );

  // {addr, data, bank_act top-bit mode, bank_act bottom-bit mode}
  localparam logic [14:0] VEC [8] = '{
    {3'd0, 4'h5, 4'b0011, 4'b0011},
    {3'd1, 4'hA, 4'b0011, 4'b1100},
    {3'd2, 4'h3, 4'b0011, 4'b0011},
    {3'd3, 4'hC, 4'b0011, 4'b1100},
    {3'd4, 4'hF, 4'b1100, 4'b0011},
    {3'd5, 4'h0, 4'b1100, 4'b1100},
    {3'd6, 4'h9, 4'b1100, 4'b0011},
    {3'd7, 4'h6, 4'b1100, 4'b1100}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    acc_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  // direct path checked in request cycle, registered path after the edge
  task automatic do_rd(input logic [2:0] a, input logic [3:0] e, input string tag);
    @(negedge clk);
    acc_en = 1'b1; wr_en = 1'b0; rd_en = 1'b1; addr = a;
    #1;
    chk(tag, 8'(rdata_l), 8'(e));
    chk(tag, 8'(rvalid_l), 8'd1);
    @(posedge clk);
    #1;
    chk(tag, 8'(rdata_h), 8'(e));
    chk(tag, 8'(rvalid_h), 8'd1);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R9: reset state of the registered read output
    chk("R9 rdata", 8'(rdata_h), 8'h0);
    chk("R9 rvalid", 8'(rvalid_h), 8'h0);
    chk("R7 idle", 8'(rvalid_l), 8'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: writes with bank selection checks
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      acc_en = 1'b1; wr_en = 1'b1; rd_en = 1'b0;
      addr = VEC[i][14:12]; wdata = VEC[i][11:8];
      #1;
      chk("R2 top-bit bank_act", 8'(act_h), 8'(VEC[i][7:4]));
      chk("R3 bottom-bit bank_act", 8'(act_l), 8'(VEC[i][3:0]));
    end
    idle();
    for (int i = 0; i < 8; i++) begin
      do_rd(VEC[i][14:12], VEC[i][11:8], "R1 readback");
    end
    idle();

    // R8: latency of the two read paths
    idle();
    @(negedge clk);
    acc_en = 1'b1; rd_en = 1'b1; wr_en = 1'b0; addr = 3'd2;
    #1;
    chk("R8 registered not yet", 8'(rvalid_h), 8'd0);
    chk("R8 direct same cycle", 8'(rvalid_l), 8'd1);
    @(posedge clk);
    #1;
    chk("R8 registered after edge", 8'(rvalid_h), 8'd1);
    chk("R8 registered data", 8'(rdata_h), 8'h3);

    // R5: write ignored without access enable
    @(negedge clk);
    acc_en = 1'b0; wr_en = 1'b1; rd_en = 1'b1; addr = 3'd3; wdata = 4'h7;
    #1;
    chk("R4 no bank top", 8'(act_h), 8'h0);
    chk("R4 no bank bottom", 8'(act_l), 8'h0);
    chk("R7 direct rdata", 8'(rdata_l), 8'h0);
    chk("R7 direct rvalid", 8'(rvalid_l), 8'h0);
    @(posedge clk);
    #1;
    chk("R7 registered rvalid", 8'(rvalid_h), 8'h0);
    do_rd(3'd3, 4'hC, "R5 word kept");

    // R6: selected but neither write nor read
    @(negedge clk);
    acc_en = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = 3'd4; wdata = 4'h2;
    #1;
    chk("R6 pair still selected", 8'(act_h), 8'b1100);
    chk("R6 direct rvalid", 8'(rvalid_l), 8'h0);
    chk("R6 direct rdata", 8'(rdata_l), 8'h0);
    @(posedge clk);
    #1;
    chk("R6 registered rvalid", 8'(rvalid_h), 8'h0);
    chk("R6 registered rdata", 8'(rdata_h), 8'h0);
    do_rd(3'd4, 4'hF, "R6 word kept");

    // R10: read and write to one word in one cycle
    @(negedge clk);
    acc_en = 1'b1; wr_en = 1'b1; rd_en = 1'b1; addr = 3'd6; wdata = 4'h1;
    #1;
    chk("R10 direct old value", 8'(rdata_l), 8'h9);
    @(posedge clk);
    #1;
    chk("R10 registered old value", 8'(rdata_h), 8'h9);
    do_rd(3'd6, 4'h1, "R1 new value after R10");

    // R9: reset in mid-run clears read register, keeps words
    do_rd(3'd0, 4'h5, "R1 before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 rdata cleared", 8'(rdata_h), 8'h0);
    chk("R9 rvalid cleared", 8'(rvalid_h), 8'h0);
    chk("R9 direct unaffected", 8'(rdata_l), 8'h5);
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    do_rd(3'd0, 4'h5, "R9 word kept");
    do_rd(3'd7, 4'h6, "R9 word kept");
    idle();
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule